// File: doc/BRIEF.md
# Flash Word Program Sequencer

This block writes a run of data words into a parallel NOR flash array, one word at a time. A single request carries a byte start address and a word count. For each word the block takes the next value from a valid/ready data source, issues the three unlock and command writes followed by the data write, and then reads the target location until it returns the written value. It then reads the location one more time to confirm the value.

The flash data bus is made of `INTERLEAVE` devices of `DEV_W` bits placed side by side. Every command value is replicated once per device lane. Command writes go to the base of the bank that holds the start address. A bank base is found from a parameter list of bank offsets, counted from the device base. A failing word ends the request with an error code: a misaligned start, a poll that never matches, or a confirm read that disagrees. A poll that never matches also writes a reset command to the device base.

The block reports the end of each request with a one-cycle `done` pulse. The error code stays readable until the next request completes.

Top module: `flash_prog_seq`

## Requirements
- R1: Out of reset the block is idle. `fl_req`, `fl_we`, `done` and `src_ready` are low and `err_code` is 0.
- R2: Each word uses exactly four bus writes, in this order: command word 0xAA to bank base + 0x555, 0x55 to bank base + 0x2AA, 0xA0 to bank base + 0x555, then the data to the target word address. A command word is the 8-bit code, zero-extended to `DEV_W` bits and repeated across all `INTERLEAVE` lanes.
- R3: A start byte address that is not a multiple of `INTERLEAVE*DEV_W/8` ends the request with `err_code` 1 (misaligned). No bus access is made and no source word is taken.
- R4: After the data write the block reads the target until the value read equals the data. It then reads the target once more to confirm. Values read during polling are compared only as whole words, and no single status bit is interpreted.
- R5: If `POLL_LIMIT` polling reads have all mismatched, `err_code` becomes 2 (timeout). One write of the 0xF0 command word then goes to the device base, which is the word address with its low `DEV_WORDS_LOG2` bits cleared, and the request ends.
- R6: A confirm read that differs from the data ends the request with `err_code` 3 (verify).
- R7: The bank base is the device base plus the largest entry of `BANK_OFFS` that does not exceed the start word's offset within the device. It is fixed for the whole request.
- R8: After each word that passes its confirm read, `src_ready` is high for one cycle, while `src_valid` is high, and the target word address advances by one. A word that fails is not taken from the source.
- R9: A start with a count of zero ends at once with `err_code` 0 and makes no bus access.
- R10: `done` is a single-cycle pulse. `err_code` changes only in a cycle where `done` is high.
- R11: A `start` pulse that arrives while a request is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, taken only when idle |
| start_addr | input | ADDR_W | Byte address of the first word |
| start_count | input | CNT_W | Number of words to program |
| src_valid | input | 1 | Source holds a word |
| src_data | input | DATA_W | Word offered by the source |
| src_ready | output | 1 | Source word consumed |
| fl_req | output | 1 | Flash bus access this cycle |
| fl_we | output | 1 | Access is a write |
| fl_addr | output | WA_W | Flash word address |
| fl_wdata | output | DATA_W | Flash write data |
| fl_rdata | input | DATA_W | Read data, valid the cycle after a read access |
| done | output | 1 | Request finished (one cycle) |
| err_code | output | 2 | 0 ok, 1 misaligned, 2 timeout, 3 verify |

## Verification
The bench targets a cell that cannot reach the data value because its bits are already cleared. A design with an off-by-one poll counter would issue one read too many or too few before the reset write, and a design that forgot the reset would leave it out of the write log. A cell that matches once and then reads back wrong catches a design that skips the confirm read. Starts placed on either side of a bank boundary, and in a second device, catch command writes sent to the wrong bank or device base. Further cases check that a failing word stays in the source, that an odd start address and a zero count cause no bus traffic, and that a second start pulse during a request does not restart it.

// File: rtl/flash_prog_pkg.sv
// Package: shared encodings for the flash word program sequencer.
// Holds error codes, controller states, command codes and the
// helper that spreads an 8-bit command across interleaved lanes.
package flash_prog_pkg;

    typedef enum logic [1:0] {
        PERR_NONE    = 2'd0,
        PERR_ALIGN   = 2'd1,
        PERR_TIMEOUT = 2'd2,
        PERR_VERIFY  = 2'd3
    } perr_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_CMD,
        S_POLL_RD,
        S_POLL_CHK,
        S_VER_RD,
        S_VER_CHK,
        S_RESET,
        S_POP,
        S_FINISH
    } pstate_e;

    localparam logic [7:0] CODE_KEY_A = 8'hAA;
    localparam logic [7:0] CODE_KEY_B = 8'h55;
    localparam logic [7:0] CODE_PROG  = 8'hA0;
    localparam logic [7:0] CODE_RESET = 8'hF0;

    localparam int KEY_ADDR_A = 'h555;
    localparam int KEY_ADDR_B = 'h2AA;

    // Zero-extend an 8-bit code to one device width and repeat it per lane.
    function automatic logic [63:0] lane_word(input logic [7:0] code,
                                              input int dev_w,
                                              input int lanes);
        logic [63:0] w;
        w = '0;
        for (int i = 0; i < 8; i++) begin
            if (i < lanes) w = w | (64'(code) << (i * dev_w));
        end
        return w;
    endfunction

endpackage

// File: rtl/flash_bank_sel.sv
// Bank selector: splits a flash word address into its device base and
// the base of the bank holding it. Assumes BANK_OFFS is ascending,
// entry 0 is zero, and all offsets lie below 2**DEV_WORDS_LOG2.
module flash_bank_sel #(
    parameter int WA_W           = 23,
    parameter int DEV_WORDS_LOG2 = 20,
    parameter int NUM_BANKS      = 4,
    parameter logic [NUM_BANKS-1:0][31:0] BANK_OFFS = '0
) (
    input  logic [WA_W-1:0] word_addr,
    output logic [WA_W-1:0] dev_base,
    output logic [WA_W-1:0] bank_base
);
    localparam logic [WA_W-1:0] DEV_MASK = ~((WA_W'(1) << DEV_WORDS_LOG2) - WA_W'(1));

    logic [WA_W-1:0]      dev_off;
    logic [NUM_BANKS-1:0] hit;
    logic [WA_W-1:0]      sel_off;

    assign dev_base = word_addr & DEV_MASK;
    assign dev_off  = word_addr & ~DEV_MASK;

    // One comparator per bank: does the bank start at or below the offset.
    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_cmp
        assign hit[gi] = (WA_W'(BANK_OFFS[gi]) <= dev_off);
    end

    // Keep the highest bank whose start is not above the offset.
    always_comb begin
        sel_off = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (hit[i]) sel_off = WA_W'(BANK_OFFS[i]);
        end
    end

    assign bank_base = dev_base + sel_off;

endmodule

// File: rtl/flash_poll_timer.sv
// Poll budget counter: counts polling reads for the current word and
// flags when LIMIT reads have been issued. Saturates at LIMIT.
module flash_poll_timer #(
    parameter int LIMIT = 10000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Count issued reads; restart at each new word.
    always_ff @(posedge clk) begin
        if (!rst_n)                            cnt <= '0;
        else if (clear)                        cnt <= '0;
        else if (tick && cnt != CW'(LIMIT))    cnt <= cnt + CW'(1);
    end

    assign expired = (cnt == CW'(LIMIT));

endmodule

// File: rtl/flash_prog_seq.sv
// Flash word program sequencer (top). Programs start_count words from a
// valid/ready source into NOR flash starting at start_addr. Assumes read
// data returns the cycle after a read access and that src_valid stays
// high with stable data until src_ready takes the word.
module flash_prog_seq
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W         = 24,
    parameter int DEV_W          = 8,
    parameter int INTERLEAVE     = 2,
    parameter int CNT_W          = 16,
    parameter int DEV_WORDS_LOG2 = 20,
    parameter int POLL_LIMIT     = 10000000,
    parameter int NUM_BANKS      = 4,
    parameter logic [NUM_BANKS-1:0][31:0] BANK_OFFS =
        {32'h000C0000, 32'h00080000, 32'h00040000, 32'h00000000},
    localparam int DATA_W    = DEV_W * INTERLEAVE,
    localparam int BUS_BYTES = DATA_W / 8,
    localparam int OFF_W     = $clog2(BUS_BYTES),
    localparam int WA_W      = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_count,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    output logic              fl_req,
    output logic              fl_we,
    output logic [WA_W-1:0]   fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    input  logic [DATA_W-1:0] fl_rdata,
    output logic              done,
    output logic [1:0]        err_code
);
    localparam logic [63:0] W_KEY_A = lane_word(CODE_KEY_A, DEV_W, INTERLEAVE);
    localparam logic [63:0] W_KEY_B = lane_word(CODE_KEY_B, DEV_W, INTERLEAVE);
    localparam logic [63:0] W_PROG  = lane_word(CODE_PROG,  DEV_W, INTERLEAVE);
    localparam logic [63:0] W_RST   = lane_word(CODE_RESET, DEV_W, INTERLEAVE);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(BUS_BYTES - 1);

    pstate_e           state;
    logic [1:0]        step;
    logic [WA_W-1:0]   wa;
    logic [WA_W-1:0]   bank_r;
    logic [WA_W-1:0]   dev_r;
    logic [CNT_W-1:0]  left;
    logic [DATA_W-1:0] data_r;
    perr_e             err_q;

    logic [WA_W-1:0]   start_wa;
    logic [WA_W-1:0]   sel_dev;
    logic [WA_W-1:0]   sel_bank;
    logic              misaligned;
    logic              poll_expired;

    assign start_wa   = WA_W'(start_addr >> OFF_W);
    assign misaligned = |(start_addr & ALIGN_MASK);

    flash_bank_sel #(
        .WA_W           (WA_W),
        .DEV_WORDS_LOG2 (DEV_WORDS_LOG2),
        .NUM_BANKS      (NUM_BANKS),
        .BANK_OFFS      (BANK_OFFS)
    ) u_bank (
        .word_addr (start_wa),
        .dev_base  (sel_dev),
        .bank_base (sel_bank)
    );

    flash_poll_timer #(
        .LIMIT (POLL_LIMIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state == S_FETCH),
        .tick    (state == S_POLL_RD),
        .expired (poll_expired)
    );

    // Sequencer: walks each word through fetch, command, poll and confirm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            step   <= '0;
            wa     <= '0;
            bank_r <= '0;
            dev_r  <= '0;
            left   <= '0;
            data_r <= '0;
            err_q  <= PERR_NONE;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        wa     <= start_wa;
                        bank_r <= sel_bank;
                        dev_r  <= sel_dev;
                        left   <= start_count;
                        if (misaligned) begin
                            err_q <= PERR_ALIGN;
                            state <= S_FINISH;
                        end else if (start_count == '0) begin
                            err_q <= PERR_NONE;
                            state <= S_FINISH;
                        end else begin
                            state <= S_FETCH;
                        end
                    end
                end
                S_FETCH: begin
                    if (src_valid) begin
                        data_r <= src_data;
                        step   <= '0;
                        state  <= S_CMD;
                    end
                end
                S_CMD: begin
                    step <= step + 2'd1;
                    if (step == 2'd3) state <= S_POLL_RD;
                end
                S_POLL_RD: state <= S_POLL_CHK;
                S_POLL_CHK: begin
                    if (fl_rdata == data_r)  state <= S_VER_RD;
                    else if (poll_expired)   state <= S_RESET;
                    else                     state <= S_POLL_RD;
                end
                S_RESET: begin
                    err_q <= PERR_TIMEOUT;
                    state <= S_FINISH;
                end
                S_VER_RD: state <= S_VER_CHK;
                S_VER_CHK: begin
                    if (fl_rdata != data_r) begin
                        err_q <= PERR_VERIFY;
                        state <= S_FINISH;
                    end else begin
                        state <= S_POP;
                    end
                end
                S_POP: begin
                    wa   <= wa + WA_W'(1);
                    left <= left - CNT_W'(1);
                    if (left == CNT_W'(1)) begin
                        err_q <= PERR_NONE;
                        state <= S_FINISH;
                    end else begin
                        state <= S_FETCH;
                    end
                end
                S_FINISH: state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    // Bus decode: address and data for each access state.
    always_comb begin
        fl_req   = 1'b0;
        fl_we    = 1'b0;
        fl_addr  = '0;
        fl_wdata = '0;
        unique case (state)
            S_CMD: begin
                fl_req = 1'b1;
                fl_we  = 1'b1;
                unique case (step)
                    2'd0: begin
                        fl_addr  = bank_r + WA_W'(KEY_ADDR_A);
                        fl_wdata = W_KEY_A[DATA_W-1:0];
                    end
                    2'd1: begin
                        fl_addr  = bank_r + WA_W'(KEY_ADDR_B);
                        fl_wdata = W_KEY_B[DATA_W-1:0];
                    end
                    2'd2: begin
                        fl_addr  = bank_r + WA_W'(KEY_ADDR_A);
                        fl_wdata = W_PROG[DATA_W-1:0];
                    end
                    default: begin
                        fl_addr  = wa;
                        fl_wdata = data_r;
                    end
                endcase
            end
            S_POLL_RD, S_VER_RD: begin
                fl_req  = 1'b1;
                fl_addr = wa;
            end
            S_RESET: begin
                fl_req   = 1'b1;
                fl_we    = 1'b1;
                fl_addr  = dev_r;
                fl_wdata = W_RST[DATA_W-1:0];
            end
            default: ;
        endcase
    end

    assign src_ready = (state == S_POP);
    assign done      = (state == S_FINISH);
    assign err_code  = err_q;

endmodule

// File: rtl/flash_prog_seq_chk.sv
// Checker for flash_prog_seq: temporal properties on its ports.
// Attached to every instance of the top through the bind below.
module flash_prog_seq_chk
    import flash_prog_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int DEV_W      = 8,
    parameter int INTERLEAVE = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic [1:0]        err_code,
    input logic              fl_req,
    input logic              fl_we,
    input logic [DATA_W-1:0] fl_wdata,
    input logic              src_valid,
    input logic              src_ready
);
    localparam logic [63:0] RST_W = lane_word(CODE_RESET, DEV_W, INTERLEAVE);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_only_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_code) |-> done);

    p_write_is_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we |-> fl_req);

    p_pop_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> src_valid);

    p_timeout_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code == 2'd2) |-> $past(fl_req && fl_we && fl_wdata == RST_W[DATA_W-1:0]));

    p_align_no_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code == 2'd1) |-> $past(!fl_req));

endmodule

bind flash_prog_seq flash_prog_seq_chk #(
    .DATA_W     (DATA_W),
    .DEV_W      (DEV_W),
    .INTERLEAVE (INTERLEAVE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .err_code  (err_code),
    .fl_req    (fl_req),
    .fl_we     (fl_we),
    .fl_wdata  (fl_wdata),
    .src_valid (src_valid),
    .src_ready (src_ready)
);

// File: tb/tb_flash_prog_seq.sv
`timescale 1ns/1ps
module tb_flash_prog_seq;

    localparam int LIMIT = 24;
    localparam logic [22:0] BOFF [4] = '{23'h000000, 23'h040000, 23'h080000, 23'h0C0000};
    localparam logic [22:0] NO_ADDR = 23'h7FFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] start_addr = '0;
    logic [15:0] start_count = '0;
    logic        src_valid = 1'b0;
    logic [15:0] src_data = '0;
    logic        src_ready;
    logic        fl_req;
    logic        fl_we;
    logic [22:0] fl_addr;
    logic [15:0] fl_wdata;
    logic [15:0] fl_rdata = '0;
    logic        done;
    logic [1:0]  err_code;

    int tests = 0;
    int fails = 0;

    flash_prog_seq #(.POLL_LIMIT(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_count(start_count), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .fl_req(fl_req), .fl_we(fl_we), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .done(done), .err_code(err_code)
    );

    always #2 clk = ~clk;

    // ---------------- flash and source models ----------------
    logic [15:0] mem [logic [22:0]];
    logic [22:0] wlog_a [$];
    logic [15:0] wlog_d [$];
    logic [15:0] srcq [$];
    int          rd_cnt = 0;
    int          pops = 0;
    int          busy_cfg = 0;
    bit          armed = 0;
    logic [22:0] pend_addr = NO_ADDR;
    logic [15:0] pend_data = '0;
    int          pend_left = 0;
    logic [22:0] flaky_addr = NO_ADDR;
    int          flaky_seen = 0;

    function automatic logic [15:0] peek(input logic [22:0] a);
        return mem.exists(a) ? mem[a] : 16'hFFFF;
    endfunction

    always @(posedge clk) begin
        logic [15:0] v;
        if (fl_req && fl_we) begin
            wlog_a.push_back(fl_addr);
            wlog_d.push_back(fl_wdata);
            if (armed) begin
                mem[fl_addr] = peek(fl_addr) & fl_wdata;
                pend_addr = fl_addr;
                pend_data = fl_wdata;
                pend_left = busy_cfg;
                armed = 0;
            end else if (fl_wdata == 16'hA0A0) begin
                armed = 1;
            end
        end else if (fl_req) begin
            rd_cnt++;
            if (fl_addr == pend_addr && pend_left > 0) begin
                v = (pend_data ^ 16'h8080) | 16'h2020;
                pend_left--;
            end else if (fl_addr == flaky_addr) begin
                v = (flaky_seen == 0) ? peek(fl_addr) : (peek(fl_addr) ^ 16'h0001);
                flaky_seen++;
            end else begin
                v = peek(fl_addr);
            end
            fl_rdata <= v;
        end
        if (src_ready && src_valid) begin
            void'(srcq.pop_front());
            pops++;
        end
    end

    always @(negedge clk) begin
        src_valid = (srcq.size() > 0);
        src_data  = (srcq.size() > 0) ? srcq[0] : 16'h0000;
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [22:0] exp_bank(input logic [22:0] w);
        logic [22:0] off;
        logic [22:0] sel;
        off = w & 23'h0FFFFF;
        sel = '0;
        for (int i = 0; i < 4; i++) if (BOFF[i] <= off) sel = BOFF[i];
        return (w & 23'h700000) + sel;
    endfunction

    // Run one request; expected outcome derived from the requirements.
    task automatic run_op(input logic [23:0] baddr, input int cnt, input int busy,
                          input bit poke);
        logic [22:0] w0, w, dev, bank;
        logic [15:0] d, cur;
        logic [1:0]  exp_err;
        logic [1:0]  err_at_done;
        int          exp_pops, exp_reads, n, nw;
        logic [22:0] ea [$];
        logic [15:0] ed [$];
        logic [15:0] sent [$];
        string       tag;
        bit          seen;

        srcq.delete();
        for (int i = 0; i < cnt + 2; i++) srcq.push_back(16'($urandom()));
        sent = srcq;
        busy_cfg = busy;
        w0 = baddr[23:1];
        dev = w0 & 23'h700000;
        bank = exp_bank(w0);
        exp_err = 2'd0; exp_pops = 0; exp_reads = 0;
        if (baddr[0]) begin
            exp_err = 2'd1;
        end else begin
            for (int i = 0; i < cnt; i++) begin
                w = w0 + 23'(i); d = sent[i]; cur = peek(w);
                ea.push_back(bank + 23'h555); ed.push_back(16'hAAAA);
                ea.push_back(bank + 23'h2AA); ed.push_back(16'h5555);
                ea.push_back(bank + 23'h555); ed.push_back(16'hA0A0);
                ea.push_back(w);              ed.push_back(d);
                if ((cur & d) != d) begin
                    ea.push_back(dev); ed.push_back(16'hF0F0);
                    exp_reads += LIMIT; exp_err = 2'd2;
                    break;
                end
                exp_reads += busy + 2;
                if (w == flaky_addr) begin exp_err = 2'd3; break; end
                exp_pops++;
            end
        end
        tag = (exp_err == 2'd1) ? "R3" : (exp_err == 2'd2) ? "R5" :
              (exp_err == 2'd3) ? "R6" : (cnt == 0) ? "R9" : "R2";

        @(negedge clk);
        wlog_a.delete(); wlog_d.delete(); rd_cnt = 0; pops = 0; flaky_seen = 0;
        start = 1'b1; start_addr = baddr; start_count = 16'(cnt);
        @(negedge clk);
        start = 1'b0;
        n = 0; seen = 0;
        while (!seen && n < 3000) begin
            if (done) seen = 1;
            else begin
                if (poke && n == 3) begin
                    start = 1'b1; start_addr = 24'h000001; start_count = 16'd7;
                end else begin
                    start = 1'b0;
                end
                @(negedge clk);
                n++;
            end
        end
        start = 1'b0;
        chk(seen, tag, "done seen", seen, 1);
        err_at_done = err_code;
        chk(err_code == exp_err, tag, "err_code", err_code, exp_err);
        chk(wlog_a.size() == ea.size(), tag, "write count", wlog_a.size(), ea.size());
        nw = (wlog_a.size() < ea.size()) ? wlog_a.size() : ea.size();
        for (int i = 0; i < nw; i++) begin
            chk(wlog_a[i] == ea[i], "R7", "write address", wlog_a[i], ea[i]);
            chk(wlog_d[i] == ed[i], "R2", "write data", wlog_d[i], ed[i]);
        end
        chk(rd_cnt == exp_reads, (exp_err == 2'd2) ? "R5" : "R4", "read count", rd_cnt, exp_reads);
        chk(pops == exp_pops, "R8", "words taken", pops, exp_pops);
        for (int i = 0; i < exp_pops; i++)
            chk(peek(w0 + 23'(i)) == sent[i], "R8", "flash content", peek(w0 + 23'(i)), sent[i]);
        @(negedge clk);
        chk(done == 1'b0, "R10", "done one cycle", done, 0);
        repeat (3) @(negedge clk);
        chk(err_code == err_at_done, "R10", "err held", err_code, err_at_done);
        if (poke) begin
            nw = wlog_a.size();
            seen = 0;
            repeat (10) begin
                @(negedge clk);
                if (done) seen = 1;
            end
            chk(!seen && wlog_a.size() == nw, "R11", "start while busy ignored",
                seen, 0);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1-R11 not finished actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [22:0] wa;
        void'($urandom(32'd7731));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(done == 0 && fl_req == 0 && src_ready == 0 && fl_we == 0, "R1", "idle outputs",
            {done, fl_req, src_ready, fl_we}, 0);
        chk(err_code == 2'd0, "R1", "reset err_code", err_code, 0);

        run_op(24'h000101, 3, 0, 0);              // R3 misaligned
        run_op(24'h000200, 0, 0, 0);              // R9 zero count
        run_op({23'h03FFFF, 1'b0}, 1, 2, 0);      // R7 last word of bank 0
        run_op({23'h040000, 1'b0}, 2, 1, 0);      // R7 first word of bank 1
        run_op({23'h1C0005, 1'b0}, 3, 3, 0);      // R7 device 1, bank 3

        wa = 23'h0A1230;                           // R5 non-blank cell times out
        mem[wa + 23'd1] = 16'h0000;
        run_op({wa, 1'b0}, 3, 0, 0);

        wa = 23'h2C4400;                           // R6 confirm read disagrees
        flaky_addr = wa + 23'd2;
        run_op({wa, 1'b0}, 4, 0, 0);
        flaky_addr = NO_ADDR;

        run_op({23'h055000, 1'b0}, 4, 2, 1);      // R11 start pulse mid-request

        // R4 random requests with random busy periods (status bit set while busy)
        for (int k = 0; k < 12; k++) begin
            wa = (23'($urandom_range(0, 3)) << 20) + BOFF[$urandom_range(0, 3)]
                 + 23'($urandom_range(0, 23'h3FFF0));
            run_op({wa, 1'b0}, $urandom_range(1, 5), $urandom_range(0, 4), 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule